// File: doc/BRIEF.md
# Buffered Fine-Resolution PWM Generator

This block drives a single pulse-width-modulated pin at a fixed repetition rate. A 10-bit timebase advances once per prescaled oscillator clock. Its two lowest bits are a fractional part, and its upper eight bits are compared against an 8-bit period setting. A period therefore always spans a whole number of groups of four timebase steps. The pulse width, by contrast, is a 10-bit value compared against the full timebase, so duty can be set four times more finely than the period.

Software writes the wanted width into a buffer: eight high bits on one port and two low bits on another. The buffer is copied into an internal active width only at the boundary between periods, so a write never produces a truncated or doubled pulse. When the enable is low the pin is held low and the timebase is held at zero. The first clock with the enable high copies the buffer and starts the first period.

Top module: `pwm10_gen`

## Requirements
- R1: While `en` is low, `pwm_o` is low from the next clock onward, and the timebase stays at zero; after reset `pwm_o` is low.
- R2: With the period setting P held constant, the output pattern repeats every (P+1)*4*N clocks, where N is the prescale factor.
- R3: The prescale select picks N as follows: 0 gives 1, 1 gives 4, and 2 or 3 give 16. The timebase advances one step every N clocks.
- R4: For a width W with 0 < W < (P+1)*4, the output is high for exactly W*N clocks at the start of each period and low for the rest of the period.
- R5: A width of zero keeps the output low for the whole period, with no pulse at the period start.
- R6: A width of (P+1)*4 or more keeps the output high for the whole period, with no low clock at the period boundary.
- R7: A change to the width buffer made in the middle of a period has no effect on that period; it takes effect from the next period start.
- R8: The first period after `en` rises uses the buffer value present when `en` rose.
- R9: The width is assembled as W = {duty_hi, duty_lo}: `duty_hi` supplies bits 9..2 and `duty_lo` supplies bits 1..0.
- R10: With N = 1 and P = 249 the period is 1000 clocks. A width of 500 gives exactly 500 high clocks per period, and a width of 1000 gives a constantly high output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, undivided |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low holds the pin low and clears the timebase |
| psc_sel | input | 2 | Prescale select (0: /1, 1: /4, 2 or 3: /16) |
| period | input | 8 | Period setting P compared with the timebase upper bits |
| duty_hi | input | 8 | Width buffer, bits 9..2 |
| duty_lo | input | 2 | Width buffer, bits 1..0 |
| pwm_o | output | 1 | PWM output pin |

## Verification
The timing properties assume that `period` and `psc_sel` are changed only while `en` is low. Under that assumption the timebase never passes the period limit, and prescale ticks stay evenly spaced. The bench respects this: it sets up every configuration during a disabled gap and alters only the width buffer while running. Mid-period writes to the width buffer are allowed and are exercised on purpose.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
    localparam int PER_W  = 8;
    localparam int FRAC_W = 2;
    localparam int DUTY_W = PER_W + FRAC_W;
    localparam int PSC_W  = 4;
    localparam int SEL_W  = 2;

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_state_t;

    typedef struct packed {
        logic [DUTY_W-1:0] tb;
    } tb_state_t;

    typedef struct packed {
        logic              armed;
        logic              out;
        logic [DUTY_W-1:0] act;
    } out_state_t;

    // terminal count (factor minus one) for a prescale select code
    function automatic logic [PSC_W-1:0] psc_limit(input logic [SEL_W-1:0] sel);
        case (sel)
            2'd0:    psc_limit = PSC_W'(0);
            2'd1:    psc_limit = PSC_W'(3);
            default: psc_limit = PSC_W'(15);
        endcase
    endfunction
endpackage

// File: rtl/pwm10_prescaler.sv
module pwm10_prescaler
    import pwm10_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    psc_state_t       st_d, st_q;
    logic [PSC_W-1:0] lim;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        lim  = psc_limit(sel);
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= lim) begin
            tick     = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
    import pwm10_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [PER_W-1:0]  period,
    output logic [DUTY_W-1:0] tb,
    output logic              wrap
);
    tb_state_t st_d, st_q;
    logic      at_end;

    always_comb begin
        st_d   = st_q;
        // last fractional step of the step group that equals the period setting
        at_end = ((st_q.tb[DUTY_W-1:FRAC_W] == period) && (&st_q.tb[FRAC_W-1:0]))
                 || (&st_q.tb);
        wrap   = run && tick && at_end;
        if (!run)      st_d.tb = '0;
        else if (wrap) st_d.tb = '0;
        else if (tick) st_d.tb = st_q.tb + 1'b1;
    end

    assign tb = st_q.tb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm10_outstage.sv
module pwm10_outstage
    import pwm10_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              wrap,
    input  logic [DUTY_W-1:0] tb,
    input  logic [DUTY_W-1:0] duty_buf,
    output logic              pwm,
    output logic              armed,
    output logic [DUTY_W-1:0] act
);
    out_state_t        st_d, st_q;
    logic [DUTY_W-1:0] tb_nxt;

    always_comb begin
        st_d   = st_q;
        tb_nxt = tb + 1'b1;
        if (!en) begin
            st_d.armed = 1'b0;
            st_d.out   = 1'b0;
        end else if (!st_q.armed) begin
            // first clock after enable: take the buffer, start period
            st_d.armed = 1'b1;
            st_d.act   = duty_buf;
            st_d.out   = (duty_buf != '0);
        end else if (wrap) begin
            st_d.act = duty_buf;
            st_d.out = (duty_buf != '0);
        end else if (tick && (tb_nxt == st_q.act)) begin
            st_d.out = 1'b0;
        end
    end

    assign pwm   = st_q.out;
    assign armed = st_q.armed;
    assign act   = st_q.act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
    import pwm10_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] psc_sel,
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] duty_hi,
    input  logic [FRAC_W-1:0] duty_lo,
    output logic             pwm_o
);
    logic              tick_w;
    logic              wrap_w;
    logic              armed_w;
    logic              run_w;
    logic [DUTY_W-1:0] tb_w;
    logic [DUTY_W-1:0] act_w;
    logic [DUTY_W-1:0] buf_w;

    assign buf_w = {duty_hi, duty_lo};
    assign run_w = en & armed_w;

    pwm10_prescaler u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .sel   (psc_sel),
        .tick  (tick_w)
    );

    pwm10_timebase u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_w),
        .tick   (tick_w),
        .period (period),
        .tb     (tb_w),
        .wrap   (wrap_w)
    );

    pwm10_outstage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick_w),
        .wrap     (wrap_w),
        .tb       (tb_w),
        .duty_buf (buf_w),
        .pwm      (pwm_o),
        .armed    (armed_w),
        .act      (act_w)
    );
endmodule

// File: rtl/pwm10_chk.sv
module pwm10_chk
    import pwm10_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              pwm_o,
    input logic              tick,
    input logic              wrap,
    input logic              armed,
    input logic [DUTY_W-1:0] tb,
    input logic [DUTY_W-1:0] act
);
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_o); // R1
    AST_TB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tb == '0)); // R1
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && armed && tick && !wrap) |=> (tb == $past(tb) + 1'b1)); // R2
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (en && armed && !tick) |=> $stable(tb)); // R3
    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> (tb == '0)); // R4
    AST_FALL_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwm_o) && $past(en)) |-> (tb == act)); // R4
    AST_ACT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !wrap) |=> $stable(act)); // R7
endmodule

bind pwm10_gen pwm10_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .pwm_o (pwm_o),
    .tick  (tick_w),
    .wrap  (wrap_w),
    .armed (armed_w),
    .tb    (tb_w),
    .act   (act_w)
);

// File: tb/sim_pwm10_gen.sv
`timescale 1ns/1ps
module sim_pwm10_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] psc_sel = 2'd0;
    logic [7:0] period = 8'd3;
    logic [7:0] duty_hi = 8'd0;
    logic [1:0] duty_lo = 2'd0;
    logic       pwm_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm10_gen u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .psc_sel (psc_sel),
        .period  (period),
        .duty_hi (duty_hi),
        .duty_lo (duty_lo),
        .pwm_o   (pwm_o)
    );

    task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    task automatic set_duty(input int w);
        duty_hi = 8'(w >> 2);   // R9 upper bits
        duty_lo = 2'(w & 3);    // R9 lower bits
    endtask

    function automatic int factor(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
    endfunction

    // Runs nper periods and checks each one: pattern mismatches and high-clock count
    task automatic run_cfg(input int sel, input int p, input int d0, input int nper,
                           input int chg_at, input int d1, input string tag);
        int n, t, full;
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        psc_sel = 2'(sel);
        period  = 8'(p);
        set_duty(d0);
        en = 1'b1;
        n = factor(sel);
        t = (p + 1) * 4 * n;
        full = (p + 1) * 4;
        for (int k = 0; k < nper; k++) begin
            int dp, hi, mism, highs;
            dp = (chg_at >= 0 && k * t > chg_at) ? d1 : d0;
            hi = ((dp > full) ? full : dp) * n;
            mism = 0;
            highs = 0;
            for (int w = 0; w < t; w++) begin
                int c;
                bit expv;
                c = k * t + w;
                @(posedge clk);
                @(negedge clk);
                expv = (w < hi);
                if (pwm_o) highs++;
                if (pwm_o !== expv) mism++;
                if (c == chg_at) set_duty(d1);
            end
            check(mism == 0 && highs == hi, tag, highs, hi);
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_o == 1'b0, "R1", pwm_o, 0); // reset state

        // sweep: small period, every prescale, widths across and beyond the period
        for (int sel = 0; sel < 4; sel++) begin
            for (int d = 0; d < 18; d++) begin
                string tag;
                if (d == 0)           tag = "R5";
                else if (d >= 16)     tag = "R6";
                else if (sel != 0)    tag = "R3";
                else if ((d % 4) != 0) tag = "R9";
                else                  tag = "R4";
                run_cfg(sel, 3, d, 2, -1, 0, tag);
            end
        end

        run_cfg(0, 7, 20, 3, -1, 0, "R2");
        run_cfg(1, 5, 9, 2, -1, 0, "R2");
        run_cfg(0, 3, 5, 3, 3, 12, "R7");    // mid-period write waits for the next period
        run_cfg(1, 3, 14, 2, 20, 2, "R7");
        run_cfg(0, 3, 3, 1, -1, 0, "R8");    // buffer changed while disabled
        run_cfg(0, 249, 500, 2, -1, 0, "R10");
        run_cfg(0, 249, 1000, 2, -1, 0, "R10");

        // R1: disable during a run with a wide pulse buffered
        run_cfg(0, 3, 15, 1, -1, 0, "R4");
        en = 1'b0;
        begin
            int highs;
            highs = 0;
            for (int i = 0; i < 20; i++) begin
                @(posedge clk);
                @(negedge clk);
                if (pwm_o) highs++;
            end
            check(highs == 0, "R1", highs, 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule